// File: doc/BRIEF.md
# SPI Register Target for a 32-Channel Discrete-Input Monitor

This block is the host-facing register interface of a discrete-input monitor. A host drives an SPI bus in mode 0: clock idle low, data sampled on the rising SCLK edge and changed on the falling edge. Every frame opens with a command byte. Its top bit picks the direction and its other seven bits name a register. Data bytes follow, most significant byte first. The block oversamples the SPI pins with its own system clock, so the SCLK rate must stay well below that clock.

Behind the interface the block holds a control word with a test switch and a soft-reset switch. It also holds one sensing-mode bit per bank of eight inputs, a test-data byte, and two 16-bit threshold words for ground-open and supply-open sensing. In each threshold word the high byte is the hysteresis and the low byte is the centre. The inputs arrive as 32 already-digitised bits. They can be read one bank at a time or as a single 32-bit word. A threshold word whose hysteresis byte is odd puts the block into a lock state, and the block then reports all inputs as zero. Only a hardware reset or a soft reset leaves the lock state.

Top module: `spi_disc_mon`

## Requirements
- R1: Frames are framed by `spi_cs_n` low and follow SPI mode 0 with MSB-first bits. The first byte is the command: bit 7 set to 1 means read and 0 means write, and bits 6..0 are the register address. On a read, the first data bit is on `spi_miso` before the ninth rising SCLK edge.
- R2: The control register is at 0x02 and occupies bits [1:0]. Bit 0 turns test mode on and appears on `test_mode`. Bit 1 is the soft-reset switch. A read returns the stored bits with the upper six bits at zero.
- R3: The sensing-mode register is at 0x04. Bit n sets the mode of bank n, which is inputs 8n+7..8n: 1 means supply-open and 0 means ground-open. Bits 3..0 are stored and shown on `bank_sense`, and bits 7..4 read as 0.
- R4: The ground-open threshold is at 0x3A and the supply-open threshold is at 0x3C. Each is 16 bits, sent and returned high byte first. The stored word and `thr_gnd`/`thr_sup` change only when the second data byte arrives. A frame that carries only the high byte leaves the word unchanged.
- R5: The input banks are read one byte each: bank 0 at 0x10, bank 1 at 0x12, bank 2 at 0x14 and bank 3 at 0x16. Bit k of bank n is input 8n+k.
- R6: A read at 0x78 returns all 32 inputs as four bytes, most significant byte first: inputs 31..24 come first.
- R7: The test-data byte is at 0x1E and can be read and written. While test mode is on, every input read returns the test-data byte in each bank position instead of the inputs.
- R8: Committing a threshold word whose high byte is odd (bit 8 of the word set) raises `lock_flag`. While locked, every input read (0x10..0x16 and 0x78) returns 0x00. The threshold value itself is still stored and can be read back.
- R9: Writing the control register with bit 1 set starts a soft reset. The lock clears, test mode goes off, and the sensing, test-data and threshold registers return to 0. The control register reads 0x02 until the host writes 0x00. While bit 1 is held, writes to the other registers are ignored and input reads return 0x00.
- R10: `rst_n` low clears every register, the lock state and the outputs to 0.
- R11: A read of an unmapped address returns 0x00, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 while not selected |
| in_bits | input | 32 | Digitised input states, bit k is input k |
| test_mode | output | 1 | Test mode active |
| bank_sense | output | 4 | Sensing mode per bank of eight inputs |
| thr_gnd | output | 16 | Ground-open threshold word (hysteresis, centre) |
| thr_sup | output | 16 | Supply-open threshold word (hysteresis, centre) |
| lock_flag | output | 1 | Lock state caused by an odd hysteresis |

## Verification
Most of the register state can be seen at the ports: a corrupted sensing bit, threshold word or lock state shows on `bank_sense`, `thr_gnd`, `thr_sup` or `lock_flag` a few system clocks after the SCLK edge that ended the byte. A wrong read mux, a wrong shift order or a missing lock mute only shows on `spi_miso` during the next read frame, so every such state is read back within one frame. A threshold committed too early, on the high byte alone, shows at once on the threshold outputs. A stale soft-reset gate shows when a write that should be ignored is read back.

// File: rtl/spi_disc_pkg.sv
package spi_disc_pkg;

  localparam logic [6:0] ADDR_CTRL    = 7'h02;
  localparam logic [6:0] ADDR_SENSE   = 7'h04;
  localparam logic [6:0] ADDR_IN_BASE = 7'h10;
  localparam logic [6:0] ADDR_TDATA   = 7'h1E;
  localparam logic [6:0] ADDR_THR_GND = 7'h3A;
  localparam logic [6:0] ADDR_THR_SUP = 7'h3C;
  localparam logic [6:0] ADDR_IN_ALL  = 7'h78;

  // Hysteresis is the high byte of a threshold word; odd means bit 8 set.
  function automatic logic hyst_odd(input logic [15:0] word);
    return word[8];
  endfunction

  // True when addr selects one of the nbanks per-bank input bytes.
  function automatic logic is_bank_addr(input logic [6:0] addr, input int nbanks);
    logic hit;
    hit = 1'b0;
    for (int n = 0; n < nbanks; n++) begin
      if (addr == ADDR_IN_BASE + 7'(2 * n)) hit = 1'b1;
    end
    return hit;
  endfunction

  // Bank number of a per-bank input address.
  function automatic int bank_of(input logic [6:0] addr);
    return int'((addr - ADDR_IN_BASE) >> 1);
  endfunction

  function automatic logic is_input_addr(input logic [6:0] addr, input int nbanks);
    return (addr == ADDR_IN_ALL) || is_bank_addr(addr, nbanks);
  endfunction

endpackage

// File: rtl/spi_disc_sync.sv
module spi_disc_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d_in;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign d_out = stg[STAGES-1];

endmodule

// File: rtl/spi_disc_frame.sv
module spi_disc_frame #(
  parameter int TX_W  = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             cs_n_s,
  input  logic             mosi_s,
  input  logic             tx_load,
  input  logic [TX_W-1:0]  tx_word,
  output logic             byte_done,
  output logic [7:0]       rx_byte,
  output logic [IDX_W-1:0] byte_idx,
  output logic             miso
);

  logic            sclk_d;
  logic            sclk_rise;
  logic            sclk_fall;
  logic [2:0]      bit_cnt;
  logic [6:0]      rx_sh;
  logic [TX_W-1:0] tx_sh;
  logic            shift_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;
  assign byte_done = sclk_rise && (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      byte_idx   <= '0;
      shift_pend <= 1'b0;
    end else if (cs_n_s) begin
      bit_cnt    <= '0;
      byte_idx   <= '0;
      tx_sh      <= '0;
      shift_pend <= 1'b0;
    end else begin
      if (sclk_rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        // data bits (not the command) earn a shift on the next falling edge
        if (byte_idx != '0) shift_pend <= 1'b1;
        if (bit_cnt == 3'd7 && byte_idx != '1) byte_idx <= byte_idx + 1'b1;
      end
      if (tx_load) begin
        tx_sh <= tx_word;
      end else if (sclk_fall && shift_pend) begin
        tx_sh      <= tx_sh << 1;
        shift_pend <= 1'b0;
      end
    end
  end

  assign miso = ~cs_n_s & tx_sh[TX_W-1];

  // R1: deselect returns the frame to the command byte
  assert_idle_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (byte_idx == '0));

  // R1: MISO moves only after a falling edge or a load
  assert_miso_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && $past(!cs_n_s) && !$past(sclk_fall) && !$past(tx_load)) |-> $stable(miso));

endmodule

// File: rtl/spi_disc_regs.sv
module spi_disc_regs
  import spi_disc_pkg::*;
#(
  parameter int NUM_IN = 32,
  parameter int IDX_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [6:0]            wr_addr,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [6:0]            rd_addr,
  input  logic [NUM_IN-1:0]     in_bits,
  output logic [NUM_IN-1:0]     rd_word,
  output logic                  test_en,
  output logic [NUM_IN/8-1:0]   sense,
  output logic [15:0]           thr_g,
  output logic [15:0]           thr_s,
  output logic                  locked
);

  localparam int NB = NUM_IN / 8;

  logic [1:0]        ctrl_q;
  logic [NB-1:0]     sense_q;
  logic [7:0]        tdata_q;
  logic [15:0]       thr_g_q;
  logic [15:0]       thr_s_q;
  logic [7:0]        hi_hold;
  logic              locked_q;
  logic [NUM_IN-1:0] in_q;
  logic [NUM_IN-1:0] in_view;

  logic first_byte, second_byte, open_gate;
  logic ctrl_wr, srst_set, sense_wr, tdata_wr;
  logic thr_g_commit, thr_s_commit, thr_commit;
  logic [15:0] commit_word;

  assign first_byte   = wr_stb && (wr_idx == IDX_W'(1));
  assign second_byte  = wr_stb && (wr_idx == IDX_W'(2));
  assign open_gate    = ~ctrl_q[1];
  assign ctrl_wr      = first_byte && (wr_addr == ADDR_CTRL);
  assign srst_set     = ctrl_wr && wr_data[1];
  assign sense_wr     = first_byte && (wr_addr == ADDR_SENSE) && open_gate;
  assign tdata_wr     = first_byte && (wr_addr == ADDR_TDATA) && open_gate;
  assign thr_g_commit = second_byte && (wr_addr == ADDR_THR_GND) && open_gate;
  assign thr_s_commit = second_byte && (wr_addr == ADDR_THR_SUP) && open_gate;
  assign thr_commit   = thr_g_commit | thr_s_commit;
  assign commit_word  = {hi_hold, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sense_q  <= '0;
      tdata_q  <= '0;
      thr_g_q  <= '0;
      thr_s_q  <= '0;
      hi_hold  <= '0;
      locked_q <= 1'b0;
      in_q     <= '0;
    end else begin
      in_q <= in_bits;
      if (first_byte) hi_hold <= wr_data;
      if (ctrl_wr) ctrl_q <= wr_data[1] ? 2'b10 : wr_data[1:0];
      if (srst_set) begin
        sense_q  <= '0;
        tdata_q  <= '0;
        thr_g_q  <= '0;
        thr_s_q  <= '0;
        locked_q <= 1'b0;
      end else begin
        if (sense_wr)     sense_q <= wr_data[NB-1:0];
        if (tdata_wr)     tdata_q <= wr_data;
        if (thr_g_commit) thr_g_q <= commit_word;
        if (thr_s_commit) thr_s_q <= commit_word;
        if (thr_commit && hyst_odd(commit_word)) locked_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (locked_q || ctrl_q[1]) in_view = '0;
    else if (ctrl_q[0])        in_view = {NB{tdata_q}};
    else                       in_view = in_q;
  end

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      ADDR_CTRL:    rd_word[NUM_IN-1 -: 8]  = {6'b0, ctrl_q};
      ADDR_SENSE:   rd_word[NUM_IN-1 -: 8]  = 8'(sense_q);
      ADDR_TDATA:   rd_word[NUM_IN-1 -: 8]  = tdata_q;
      ADDR_THR_GND: rd_word[NUM_IN-1 -: 16] = thr_g_q;
      ADDR_THR_SUP: rd_word[NUM_IN-1 -: 16] = thr_s_q;
      ADDR_IN_ALL:  rd_word                 = in_view;
      default: begin
        if (is_bank_addr(rd_addr, NB))
          rd_word[NUM_IN-1 -: 8] = in_view[bank_of(rd_addr)*8 +: 8];
      end
    endcase
  end

  assign test_en = ctrl_q[0];
  assign sense   = sense_q;
  assign thr_g   = thr_g_q;
  assign thr_s   = thr_s_q;
  assign locked  = locked_q;

  assert_lock_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(thr_commit && hyst_odd(commit_word)));

  assert_srst_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_set |=> !locked_q);

  assert_srst_blocks_sense_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1] |=> $stable(sense_q));

  assert_thr_commit_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(thr_g_q) |-> $past(thr_g_commit || srst_set));

endmodule

// File: rtl/spi_disc_mon.sv
module spi_disc_mon
  import spi_disc_pkg::*;
#(
  parameter int NUM_IN      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sclk,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  input  logic [NUM_IN-1:0]   in_bits,
  output logic                test_mode,
  output logic [NUM_IN/8-1:0] bank_sense,
  output logic [15:0]         thr_gnd,
  output logic [15:0]         thr_sup,
  output logic                lock_flag
);

  localparam int NB    = NUM_IN / 8;
  localparam int IDX_W = 3;

  logic             sclk_s, cs_n_s, mosi_s;
  logic             byte_done;
  logic [7:0]       rx_byte;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       cmd_q;
  logic             tx_load;
  logic             wr_stb;
  logic [NUM_IN-1:0] rd_word;

  spi_disc_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in ({spi_sclk, spi_cs_n, spi_mosi}),
    .d_out({sclk_s, cs_n_s, mosi_s})
  );

  spi_disc_frame #(
    .TX_W (NUM_IN),
    .IDX_W(IDX_W)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (sclk_s),
    .cs_n_s   (cs_n_s),
    .mosi_s   (mosi_s),
    .tx_load  (tx_load),
    .tx_word  (rd_word),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .byte_idx (byte_idx),
    .miso     (spi_miso)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cmd_q <= '0;
    else if (byte_done && byte_idx == '0)  cmd_q <= rx_byte;
  end

  assign tx_load = byte_done && (byte_idx == '0) && rx_byte[7];
  assign wr_stb  = byte_done && (byte_idx != '0) && !cmd_q[7];

  spi_disc_regs #(
    .NUM_IN(NUM_IN),
    .IDX_W (IDX_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .wr_addr(cmd_q[6:0]),
    .wr_idx (byte_idx),
    .wr_data(rx_byte),
    .rd_addr(rx_byte[6:0]),
    .in_bits(in_bits),
    .rd_word(rd_word),
    .test_en(test_mode),
    .sense  (bank_sense),
    .thr_g  (thr_gnd),
    .thr_s  (thr_sup),
    .locked (lock_flag)
  );

  assert_lock_mutes_inputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && lock_flag && is_input_addr(rx_byte[6:0], NB)) |-> (rd_word == '0));

endmodule

// File: tb/spi_disc_mon_tb_top.sv
module spi_disc_mon_tb_top;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic [31:0] in_bits = '0;
  logic        test_mode;
  logic [3:0]  bank_sense;
  logic [15:0] thr_gnd, thr_sup;
  logic        lock_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_disc_mon dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .in_bits(in_bits),
    .test_mode(test_mode), .bank_sense(bank_sense), .thr_gnd(thr_gnd),
    .thr_sup(thr_sup), .lock_flag(lock_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic frame_open();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_close();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] addr, input int n, input logic [31:0] data);
    logic [7:0] junk;
    frame_open();
    spi_byte({1'b0, addr}, junk);
    for (int k = 0; k < n; k++) spi_byte(data[8*(n-1-k) +: 8], junk);
    frame_close();
  endtask

  task automatic rd(input logic [6:0] addr, input int n, output logic [31:0] val);
    logic [7:0] b;
    val = '0;
    frame_open();
    spi_byte({1'b1, addr}, b);
    for (int k = 0; k < n; k++) begin
      spi_byte(8'h00, b);
      val = {val[23:0], b};
    end
    frame_close();
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check("R10 lock after reset", 32'(lock_flag), 0);
    check("R10 thr_gnd after reset", 32'(thr_gnd), 0);
    rd(7'h02, 1, v); check("R10 ctrl after reset", v, 0);
    rd(7'h3C, 2, v); check("R10 sup threshold after reset", v, 0);
  endtask

  task automatic t_sense();
    logic [31:0] v;
    wr(7'h04, 1, 32'hF5);
    rd(7'h04, 1, v); check("R3 sense readback masks upper bits", v, 32'h05);
    check("R3 bank_sense output", 32'(bank_sense), 32'h5);
  endtask

  task automatic t_threshold();
    logic [31:0] v;
    wr(7'h3A, 2, 32'h0206);
    rd(7'h3A, 2, v); check("R4 gnd threshold high byte first", v, 32'h0206);
    check("R4 thr_gnd output", 32'(thr_gnd), 32'h0206);
    wr(7'h3C, 2, 32'h0814);
    check("R4 thr_sup output", 32'(thr_sup), 32'h0814);
    wr(7'h3A, 1, 32'h09);
    check("R4 high byte alone does not commit", 32'(thr_gnd), 32'h0206);
    check("R8 no lock without commit", 32'(lock_flag), 0);
  endtask

  task automatic t_inputs();
    logic [31:0] v;
    in_bits = 32'hA1B2C3D4;
    repeat (4) @(negedge clk);
    rd(7'h10, 1, v); check("R5 bank0", v, 32'hD4);
    rd(7'h12, 1, v); check("R5 bank1", v, 32'hC3);
    rd(7'h14, 1, v); check("R5 bank2", v, 32'hB2);
    rd(7'h16, 1, v); check("R5 bank3", v, 32'hA1);
    rd(7'h78, 4, v); check("R6 all inputs MSB first", v, 32'hA1B2C3D4);
    in_bits = 32'h0F00FF01;
    repeat (4) @(negedge clk);
    rd(7'h78, 4, v); check("R6 all inputs second pattern", v, 32'h0F00FF01);
    rd(7'h10, 2, v); check("R1 read past data gives zeros", v, 32'h0100);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(7'h20, 1, 32'hFF);
    rd(7'h20, 1, v); check("R11 unmapped read zero", v, 0);
    rd(7'h04, 1, v); check("R11 unmapped write leaves sense", v, 32'h05);
    rd(7'h3A, 2, v); check("R11 unmapped write leaves threshold", v, 32'h0206);
  endtask

  task automatic t_test_mode();
    logic [31:0] v;
    wr(7'h1E, 1, 32'h5A);
    rd(7'h1E, 1, v); check("R7 test data readback", v, 32'h5A);
    wr(7'h02, 1, 32'h01);
    check("R2 test_mode output", 32'(test_mode), 1);
    rd(7'h02, 1, v); check("R2 ctrl readback", v, 32'h01);
    rd(7'h12, 1, v); check("R7 bank read in test mode", v, 32'h5A);
    rd(7'h78, 4, v); check("R7 all read in test mode", v, 32'h5A5A5A5A);
    wr(7'h02, 1, 32'h00);
    rd(7'h78, 4, v); check("R7 inputs back after test mode", v, 32'h0F00FF01);
  endtask

  task automatic t_lock_and_soft_reset();
    logic [31:0] v;
    wr(7'h3C, 2, 32'h0306);
    check("R8 odd hysteresis locks", 32'(lock_flag), 1);
    rd(7'h78, 4, v); check("R8 locked all read zero", v, 0);
    rd(7'h14, 1, v); check("R8 locked bank read zero", v, 0);
    rd(7'h3C, 2, v); check("R8 odd word still stored", v, 32'h0306);
    wr(7'h02, 1, 32'h03);
    check("R9 soft reset clears lock", 32'(lock_flag), 0);
    check("R9 soft reset clears test mode", 32'(test_mode), 0);
    rd(7'h02, 1, v); check("R9 ctrl reads srst bit only", v, 32'h02);
    rd(7'h04, 1, v); check("R9 sense cleared", v, 0);
    rd(7'h3A, 2, v); check("R9 threshold cleared", v, 0);
    wr(7'h04, 1, 32'h0F);
    check("R9 write ignored while held", 32'(bank_sense), 0);
    rd(7'h78, 4, v); check("R9 inputs muted while held", v, 0);
    wr(7'h02, 1, 32'h00);
    rd(7'h78, 4, v); check("R9 inputs after release", v, 32'h0F00FF01);
    wr(7'h04, 1, 32'h0A);
    check("R9 writes accepted after release", 32'(bank_sense), 32'hA);
  endtask

  task automatic t_hw_reset();
    wr(7'h3A, 2, 32'h0104);
    check("R8 lock via gnd threshold", 32'(lock_flag), 1);
    hw_reset();
    check("R10 hw reset clears lock", 32'(lock_flag), 0);
    check("R10 hw reset clears thr_gnd", 32'(thr_gnd), 0);
    check("R10 hw reset clears bank_sense", 32'(bank_sense), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_sense();
    t_threshold();
    t_inputs();
    t_unmapped();
    t_test_mode();
    t_lock_and_soft_reset();
    t_hw_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule